// File: doc/BRIEF.md
# Abstract Register-Access Command Sequencer

This block sits inside a debug unit and turns a 32-bit abstract command from a debugger into a two-word instruction stub that a halted hart executes. For a register-access command it builds one load or store instruction and one exit instruction. The load or store moves a general-purpose register to or from a fixed data area. The exit instruction is either a return to the debug loop or a jump into the program buffer. The block then raises the "go" flag of the selected hart. The hart clears that flag with an acknowledge when it picks up the stub.

Command fields sit at fixed bit positions: bits [31:24] give the command kind, [22:20] the access size, bit 18 the post-execute request, bit 17 the transfer request, bit 16 the direction (1 loads the register from the data area), and [15:0] the register number. Bits 23 and 19 are ignored. The data-area address, the program buffer length and the stub length are parameters. The jump offset follows from them: the program buffer starts at `DATA_START − (4 + 4·PROGBUF_WORDS)`, and the stub sits `4·ABSTRACT_WORDS` bytes below that. The data-area address must fit a 12-bit signed offset.

Errors go into a 3-bit error field (0 none, 1 busy, 2 not supported). Software clears the field by writing ones to the bits it wants to clear. The hart-select value keeps only `HARTSEL_W` bits.

Top module: `dbg_abs_cmd_seq`

## Requirements
- R1: After reset all go flags are 0, the error field is 0, the hart select reads 0 and both stub words hold ebreak (0x00100073).
- R2: A command whose bits [31:24] are not zero sets the error field to 2 and changes neither the stub nor the go flags.
- R3: With transfer set, a register number outside 0x1000..0x101F sets the error field to 2 and executes nothing.
- R4: With transfer set, a size other than 2 or 3 sets the error field to 2 and executes nothing.
- R5: With transfer and write set, stub word 0 is an I-type load (opcode 0000011, funct3 010 for size 2 and 011 for size 3), rd = register number − 0x1000, base x0, offset = data-area address.
- R6: With transfer set and write clear, stub word 0 is an S-type store (opcode 0100011, same funct3 values), rs2 = register number − 0x1000, base x0, offset = data-area address.
- R7: With post-execute set, stub word 1 is jal x0 with offset (progbuf_start − abstract_start − 4), which is 0x0040006F at default parameters. Otherwise stub word 1 is ebreak.
- R8: With transfer clear, stub word 0 is a no-op (0x00000013). Size and register number are not checked, no error is raised, and go is still raised.
- R9: One cycle after an accepted command, only the go bit of the selected hart is set. At most one go bit is ever set.
- R10: A command that arrives while any go bit is set sets the error field to 1 and leaves both stub words and the go flags unchanged.
- R11: Acknowledging a hart clears its go bit on the next cycle.
- R12: Error clear writes clear only the error-field bits given as ones in the mask. Bits given as zeros keep their value.
- R13: Only the low `HARTSEL_W` bits of a hart-select write are stored. The upper bits of the 10-bit readback are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Abstract command write strobe |
| cmd_i | input | 32 | Abstract command word |
| sel_wr_i | input | 1 | Hart-select write strobe |
| sel_wdata_i | input | 10 | Hart-select write value |
| err_clr_i | input | 1 | Error-field clear strobe |
| err_clr_mask_i | input | 3 | Ones clear the matching error bits |
| go_ack_i | input | 2**HARTSEL_W | Per-hart acknowledge, clears go |
| sel_o | output | 10 | Hart-select readback |
| cmderr_o | output | 3 | Error field |
| stub0_o | output | 32 | Stub word 0 (transfer instruction) |
| stub1_o | output | 32 | Stub word 1 (exit instruction) |
| go_o | output | 2**HARTSEL_W | Per-hart go flags |

## Verification
Every result is registered once. The stub words, go flags, error field and hart select all change on the first rising edge after the input strobe, and an acknowledge clears go on that same edge. The bench changes inputs on the falling edge, holds a strobe for one cycle, and reads the outputs on the next falling edge, half a cycle after the edge that captured them. Rejected commands are checked by comparing both stub words and the go flags against the values held before the command.

// File: rtl/dbg_acs_pkg.sv
package dbg_acs_pkg;

  localparam logic [2:0] ERR_NONE   = 3'd0;
  localparam logic [2:0] ERR_BUSY   = 3'd1;
  localparam logic [2:0] ERR_NOTSUP = 3'd2;

  localparam logic [31:0] INSN_EBREAK = 32'h0010_0073;
  localparam logic [31:0] INSN_NOP    = 32'h0000_0013;

  localparam logic [6:0] OPC_LOAD  = 7'b0000011;
  localparam logic [6:0] OPC_STORE = 7'b0100011;
  localparam logic [6:0] OPC_JAL   = 7'b1101111;

  typedef struct packed {
    logic [7:0]  kind;
    logic        rsvd_a;
    logic [2:0]  size;
    logic        rsvd_b;
    logic        postexec;
    logic        transfer;
    logic        write;
    logic [15:0] regno;
  } acmd_t;

  function automatic logic [31:0] enc_load(input logic [4:0] rd, input logic [2:0] f3,
                                           input logic [11:0] imm);
    return {imm, 5'd0, f3, rd, OPC_LOAD};
  endfunction

  function automatic logic [31:0] enc_store(input logic [4:0] rs2, input logic [2:0] f3,
                                            input logic [11:0] imm);
    return {imm[11:5], rs2, 5'd0, f3, imm[4:0], OPC_STORE};
  endfunction

  // off_hw holds offset bits [20:1]
  function automatic logic [31:0] enc_jal(input logic [4:0] rd, input logic [19:0] off_hw);
    return {off_hw[19], off_hw[9:0], off_hw[10], off_hw[18:11], rd, OPC_JAL};
  endfunction

endpackage

// File: rtl/acs_decode.sv
module acs_decode
  import dbg_acs_pkg::*;
(
  input  acmd_t      cmd_i,
  input  logic       busy_i,
  output logic       accept_o,
  output logic [2:0] err_o
);
  logic kind_ok, reg_ok, size_ok;

  assign kind_ok = (cmd_i.kind == 8'h00);
  assign reg_ok  = (cmd_i.regno[15:5] == 11'h080);
  assign size_ok = (cmd_i.size == 3'd2) || (cmd_i.size == 3'd3);

  always_comb begin
    accept_o = 1'b0;
    err_o    = ERR_NONE;
    if (busy_i)                                          err_o = ERR_BUSY;
    else if (!kind_ok)                                   err_o = ERR_NOTSUP;
    else if (cmd_i.transfer && (!reg_ok || !size_ok))    err_o = ERR_NOTSUP;
    else                                                 accept_o = 1'b1;
  end
endmodule

// File: rtl/acs_stub_gen.sv
module acs_stub_gen
  import dbg_acs_pkg::*;
#(
  parameter logic [11:0] DATA_IMM = 12'h380,
  parameter logic [20:0] JAL_IMM  = 21'd4
) (
  input  acmd_t       cmd_i,
  output logic [31:0] word0_o,
  output logic [31:0] word1_o
);
  logic [2:0] f3;
  logic [4:0] gpr;

  assign f3  = {1'b0, cmd_i.size[1:0]};
  assign gpr = cmd_i.regno[4:0];

  always_comb begin
    if (!cmd_i.transfer)   word0_o = INSN_NOP;
    else if (cmd_i.write)  word0_o = enc_load(gpr, f3, DATA_IMM);
    else                   word0_o = enc_store(gpr, f3, DATA_IMM);
  end

  assign word1_o = cmd_i.postexec ? enc_jal(5'd0, JAL_IMM[20:1]) : INSN_EBREAK;
endmodule

// File: rtl/acs_go_flags.sv
module acs_go_flags #(
  parameter int HARTSEL_W = 2,
  localparam int NHARTS   = 1 << HARTSEL_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 set_i,
  input  logic [HARTSEL_W-1:0] sel_i,
  input  logic [NHARTS-1:0]    ack_i,
  output logic [NHARTS-1:0]    go_o
);
  for (genvar h = 0; h < NHARTS; h++) begin : g_hart
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   go_o[h] <= 1'b0;
      else if (set_i && sel_i == HARTSEL_W'(h))      go_o[h] <= 1'b1;
      else if (ack_i[h])                             go_o[h] <= 1'b0;
    end
  end
endmodule

// File: rtl/dbg_abs_cmd_seq.sv
module dbg_abs_cmd_seq
  import dbg_acs_pkg::*;
#(
  parameter int HARTSEL_W      = 2,
  parameter int PROGBUF_WORDS  = 2,
  parameter int ABSTRACT_WORDS = 2,
  parameter int DATA_START     = 'h380,
  localparam int NHARTS        = 1 << HARTSEL_W,
  localparam int SEL_FIELD_W   = 10
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cmd_valid_i,
  input  logic [31:0]            cmd_i,
  input  logic                   sel_wr_i,
  input  logic [SEL_FIELD_W-1:0] sel_wdata_i,
  input  logic                   err_clr_i,
  input  logic [2:0]             err_clr_mask_i,
  input  logic [NHARTS-1:0]      go_ack_i,
  output logic [SEL_FIELD_W-1:0] sel_o,
  output logic [2:0]             cmderr_o,
  output logic [31:0]            stub0_o,
  output logic [31:0]            stub1_o,
  output logic [NHARTS-1:0]      go_o
);
  localparam int PROGBUF_START = DATA_START - (4 + 4 * PROGBUF_WORDS);
  localparam int ABS_START     = PROGBUF_START - 4 * ABSTRACT_WORDS;
  localparam int JAL_OFF       = PROGBUF_START - ABS_START - 4;
  localparam logic [11:0] DATA_IMM = 12'(DATA_START);
  localparam logic [20:0] JAL_IMM  = 21'(JAL_OFF);

  acmd_t                cmd;
  logic                 accept;
  logic [2:0]           dec_err;
  logic [31:0]          word0, word1;
  logic [HARTSEL_W-1:0] sel_q;
  logic                 unused_bits;

  assign cmd         = cmd_i;
  assign unused_bits = ^{cmd.rsvd_a, cmd.rsvd_b, sel_wdata_i[SEL_FIELD_W-1:HARTSEL_W]};

  acs_decode u_decode (
    .cmd_i    (cmd),
    .busy_i   (|go_o),
    .accept_o (accept),
    .err_o    (dec_err)
  );

  acs_stub_gen #(
    .DATA_IMM (DATA_IMM),
    .JAL_IMM  (JAL_IMM)
  ) u_stub (
    .cmd_i   (cmd),
    .word0_o (word0),
    .word1_o (word1)
  );

  acs_go_flags #(
    .HARTSEL_W (HARTSEL_W)
  ) u_go (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (cmd_valid_i && accept),
    .sel_i  (sel_q),
    .ack_i  (go_ack_i),
    .go_o   (go_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stub0_o <= INSN_EBREAK;
      stub1_o <= INSN_EBREAK;
    end else if (cmd_valid_i && accept) begin
      stub0_o <= word0;
      stub1_o <= word1;
    end
  end

  // a new error wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               cmderr_o <= ERR_NONE;
    else if (cmd_valid_i && dec_err != ERR_NONE) cmderr_o <= dec_err;
    else if (err_clr_i)                        cmderr_o <= cmderr_o & ~err_clr_mask_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sel_q <= '0;
    else if (sel_wr_i) sel_q <= sel_wdata_i[HARTSEL_W-1:0];
  end

  assign sel_o = SEL_FIELD_W'(sel_q);
endmodule

// File: rtl/acs_checker.sv
module acs_checker #(
  parameter int HARTSEL_W = 2,
  localparam int NHARTS   = 1 << HARTSEL_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic [31:0]       cmd_i,
  input logic [NHARTS-1:0] go_ack_i,
  input logic [2:0]        cmderr_o,
  input logic [31:0]       stub0_o,
  input logic [31:0]       stub1_o,
  input logic [NHARTS-1:0] go_o
);
  AST_GO_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(go_o)); // R9

  AST_GO_FROM_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((go_o & ~$past(go_o)) != '0) |-> $past(cmd_valid_i)); // R9

  AST_BUSY_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && go_o != '0) |=> cmderr_o == 3'd1); // R10

  AST_BUSY_STUB_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && go_o != '0) |=> ($stable(stub0_o) && $stable(stub1_o))); // R10

  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((go_o & go_ack_i) != '0) |=> ((go_o & $past(go_o & go_ack_i)) == '0)); // R11

  AST_KIND_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_i[31:24] != 8'h00 && go_o == '0) |=> (go_o == '0 && cmderr_o == 3'd2)); // R2

  AST_ERR_FROM_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmderr_o != 3'd0 && $past(cmderr_o) == 3'd0) |-> $past(cmd_valid_i)); // R2
endmodule

bind dbg_abs_cmd_seq acs_checker #(.HARTSEL_W(HARTSEL_W)) u_acs_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .cmd_i       (cmd_i),
  .go_ack_i    (go_ack_i),
  .cmderr_o    (cmderr_o),
  .stub0_o     (stub0_o),
  .stub1_o     (stub1_o),
  .go_o        (go_o)
);

// File: tb/dbg_abs_cmd_seq_bench.sv
`timescale 1ns/1ps
module dbg_abs_cmd_seq_bench;
  localparam logic [31:0] EBREAK = 32'h0010_0073;
  localparam logic [31:0] NOP    = 32'h0000_0013;
  localparam logic [31:0] JAL4   = 32'h0040_006F;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic [31:0] cmd_i = '0;
  logic        sel_wr_i = 1'b0;
  logic [9:0]  sel_wdata_i = '0;
  logic        err_clr_i = 1'b0;
  logic [2:0]  err_clr_mask_i = '0;
  logic [3:0]  go_ack_i = '0;
  logic [9:0]  sel_o;
  logic [2:0]  cmderr_o;
  logic [31:0] stub0_o, stub1_o;
  logic [3:0]  go_o;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  dbg_abs_cmd_seq u_dbg_abs_cmd_seq (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_i(cmd_i),
    .sel_wr_i(sel_wr_i), .sel_wdata_i(sel_wdata_i), .err_clr_i(err_clr_i),
    .err_clr_mask_i(err_clr_mask_i), .go_ack_i(go_ack_i), .sel_o(sel_o),
    .cmderr_o(cmderr_o), .stub0_o(stub0_o), .stub1_o(stub1_o), .go_o(go_o)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [2:0] size, input logic post,
                                     input logic xfer, input logic wr, input logic [15:0] regno);
    return {8'h00, 1'b0, size, 1'b0, post, xfer, wr, regno};
  endfunction

  task automatic send(input logic [31:0] c);
    @(negedge clk); cmd_i = c; cmd_valid_i = 1'b1;
    @(negedge clk); cmd_valid_i = 1'b0;
  endtask

  task automatic ack(input int h);
    @(negedge clk); go_ack_i = 4'(1 << h);
    @(negedge clk); go_ack_i = '0;
  endtask

  task automatic clr(input logic [2:0] m);
    @(negedge clk); err_clr_i = 1'b1; err_clr_mask_i = m;
    @(negedge clk); err_clr_i = 1'b0;
  endtask

  task automatic set_sel(input logic [9:0] v);
    @(negedge clk); sel_wr_i = 1'b1; sel_wdata_i = v;
    @(negedge clk); sel_wr_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1", "go", 32'(go_o), 32'h0);
    chk("R1", "err", 32'(cmderr_o), 32'h0);
    chk("R1", "sel", 32'(sel_o), 32'h0);
    chk("R1", "stub0", stub0_o, EBREAK);
    chk("R1", "stub1", stub1_o, EBREAK);
  endtask

  task automatic t_load32_busy;
    set_sel(10'd1);
    send(mk(3'd2, 1'b0, 1'b1, 1'b1, 16'h1005));
    chk("R5", "lw x5", stub0_o, 32'h3800_2283);
    chk("R7", "ebreak exit", stub1_o, EBREAK);
    chk("R9", "go hart1", 32'(go_o), 32'h2);
    chk("R9", "err after ok", 32'(cmderr_o), 32'h0);
    send(mk(3'd3, 1'b1, 1'b1, 1'b0, 16'h1007));
    chk("R10", "busy err", 32'(cmderr_o), 32'h1);
    chk("R10", "stub0 held", stub0_o, 32'h3800_2283);
    chk("R10", "stub1 held", stub1_o, EBREAK);
    chk("R10", "go held", 32'(go_o), 32'h2);
    clr(3'b010);
    chk("R12", "zero mask keeps", 32'(cmderr_o), 32'h1);
    clr(3'b001);
    chk("R12", "one mask clears", 32'(cmderr_o), 32'h0);
    ack(1);
    chk("R11", "ack clears", 32'(go_o), 32'h0);
  endtask

  task automatic t_store64_post;
    set_sel(10'd3);
    send(mk(3'd3, 1'b1, 1'b1, 1'b0, 16'h1005));
    chk("R6", "sd x5", stub0_o, 32'h3850_3023);
    chk("R7", "jal exit", stub1_o, JAL4);
    chk("R9", "go hart3", 32'(go_o), 32'h8);
    ack(3);
  endtask

  task automatic t_edges;
    set_sel(10'd0);
    send(mk(3'd3, 1'b0, 1'b1, 1'b1, 16'h101F));
    chk("R5", "ld x31", stub0_o, 32'h3800_3F83);
    chk("R7", "ebreak exit", stub1_o, EBREAK);
    ack(0);
    send(mk(3'd2, 1'b0, 1'b1, 1'b0, 16'h1000));
    chk("R6", "sw x0", stub0_o, 32'h3800_2023);
    ack(0);
    chk("R11", "go idle", 32'(go_o), 32'h0);
  endtask

  task automatic t_reject;
    send(mk(3'd2, 1'b0, 1'b1, 1'b1, 16'h1020));
    chk("R3", "regno 0x1020 err", 32'(cmderr_o), 32'h2);
    chk("R3", "regno 0x1020 go", 32'(go_o), 32'h0);
    chk("R3", "regno 0x1020 stub", stub0_o, 32'h3800_2023);
    clr(3'b111);
    send(mk(3'd2, 1'b0, 1'b1, 1'b1, 16'h0FFF));
    chk("R3", "regno 0x0FFF err", 32'(cmderr_o), 32'h2);
    chk("R3", "regno 0x0FFF go", 32'(go_o), 32'h0);
    clr(3'b111);
    send(mk(3'd1, 1'b0, 1'b1, 1'b1, 16'h1005));
    chk("R4", "size1 err", 32'(cmderr_o), 32'h2);
    clr(3'b111);
    send(mk(3'd4, 1'b1, 1'b1, 1'b0, 16'h1005));
    chk("R4", "size4 err", 32'(cmderr_o), 32'h2);
    chk("R4", "size4 stub1", stub1_o, EBREAK);
    chk("R4", "size4 go", 32'(go_o), 32'h0);
    clr(3'b111);
    send(32'h0100_0000 | mk(3'd2, 1'b0, 1'b1, 1'b1, 16'h1005));
    chk("R2", "kind err", 32'(cmderr_o), 32'h2);
    chk("R2", "kind go", 32'(go_o), 32'h0);
    chk("R2", "kind stub", stub0_o, 32'h3800_2023);
    clr(3'b111);
  endtask

  task automatic t_no_transfer;
    send(mk(3'd5, 1'b1, 1'b0, 1'b0, 16'h0000));
    chk("R8", "no error", 32'(cmderr_o), 32'h0);
    chk("R8", "nop word", stub0_o, NOP);
    chk("R8", "jal word", stub1_o, JAL4);
    chk("R8", "go hart0", 32'(go_o), 32'h1);
    ack(0);
  endtask

  task automatic t_sel_width;
    set_sel(10'h3FE);
    chk("R13", "sel readback", 32'(sel_o), 32'h2);
    send(mk(3'd2, 1'b0, 1'b1, 1'b1, 16'h1001));
    chk("R13", "go hart2", 32'(go_o), 32'h4);
    chk("R5", "lw x1", stub0_o, 32'h3800_2083);
    ack(2);
  endtask

  initial begin
    #(5.0 * 100000);
    bad++; total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_load32_busy();
    t_store64_post();
    t_edges();
    t_reject();
    t_no_transfer();
    t_sel_width();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule